// File: doc/BRIEF.md
# Dual-Bank Interrupt Aggregator

This block collects sixty-four interrupt request lines and presents them to software as two groups of thirty-two. The low group holds sources 0 to 31. The high group holds sources 32 to 63. For each group, software sees four 32-bit words on a small register bus:
- a pending word, which latches requests;
- an enable word;
- an acknowledge word, which is write-one-to-clear;
- a raw-level word, which shows the live state of the inputs.

A request is captured on the rising edge of its line, and only while that source is enabled. A captured request stays pending until software acknowledges it. The single processor interrupt line is the registered OR of every request that is both pending and enabled.

Reads are registered. Read data appears on the cycle after the read strobe and holds until the next read. Writes take effect at the clock edge that samples the write strobe.

Top module: `irq_agg_top`

## Requirements
- R1: After a synchronous reset (`rst` high), `irq_out` and `bus_rdata` are 0, and every pending and enable bit is 0.
- R2: The word offsets are as follows. Addresses with nonzero bits [1:0], and all other addresses, read as 0.

| Offset | Group | Word |
|---|---|---|
| 0x10 | sources 32..63 | pending |
| 0x14 | sources 32..63 | enable |
| 0x18 | sources 32..63 | acknowledge |
| 0x1C | sources 32..63 | raw level |
| 0x20 | sources 0..31 | pending |
| 0x24 | sources 0..31 | enable |
| 0x28 | sources 0..31 | acknowledge |
| 0x2C | sources 0..31 | raw level |

  Bit i of a high-group word is source 32+i.
- R3: A 0-to-1 transition on an enabled source sets its pending bit. A line held high sets the bit only once, so once it is acknowledged it stays clear until a new rising edge.
- R4: A rising edge on a source whose enable bit is 0 leaves its pending bit unchanged.
- R5: Writing 1 to a bit of an acknowledge word clears that pending bit. Writing 0 leaves it unchanged.
- R6: When a rising edge on an enabled source and an acknowledge of the same bit fall in the same cycle, the bit ends up set.
- R7: A raw-level word reads the current input lines of its group, whatever the enable and pending state.
- R8: `irq_out` is 1 one cycle after any bit of (pending AND enable) is 1 in either group. Clearing the enable bit drops `irq_out` but leaves the pending bit set.
- R9: Acknowledge words read as 0. Writes to pending and raw-level words change nothing.
- R10: `bus_rdata` changes only on the cycle after `bus_rd` is sampled high, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | 64 | Interrupt request lines, source n on bit n |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_out | output | 1 | Combined processor interrupt |

## Verification
The assertions check four behaviours on every cycle:
- no pending bit ever rises unless its source had an edge while enabled;
- an enabled edge always leaves the bit set, even against a same-cycle acknowledge;
- no pending bit falls without an acknowledge;
- read data holds between reads, and the interrupt line tracks pending AND enable with one cycle of delay.

Only the bench scenarios can show the rest: the offset map and the bit ordering within a group, the level readback, the once-per-edge behaviour of a held line, and that writes to read-only words are ignored.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned GRP_W   = 32;
  localparam int unsigned N_GRP   = 2;
  localparam int unsigned ADDR_W  = 8;

  // register select, taken from address bits [3:2]
  typedef enum logic [1:0] {
    SEL_PEND  = 2'd0,
    SEL_ENA   = 2'd1,
    SEL_ACK   = 2'd2,
    SEL_LEVEL = 2'd3
  } reg_sel_e;

  // address bits [7:4] that select each group; group 0 = sources 0..31
  function automatic logic [3:0] grp_page(input int unsigned g);
    return (g == 0) ? 4'h2 : 4'h1;
  endfunction
endpackage

// File: rtl/irq_bank.sv
module irq_bank #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] src,
  input  logic         ena_we,
  input  logic [W-1:0] ena_wdata,
  input  logic [W-1:0] ack_bits,
  output logic [W-1:0] pend,
  output logic [W-1:0] ena,
  output logic [W-1:0] level
);
  logic [W-1:0] src_q;
  logic [W-1:0] rise;

  assign rise  = src & ~src_q;
  assign level = src;

  // previous-level register follows the lines during reset,
  // so a line already high at release is not an edge
  always_ff @(posedge clk) begin
    src_q <= src;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ena <= '0;
    end else if (ena_we) begin
      ena <= ena_wdata;
    end
  end

  // an enabled edge wins over an acknowledge in the same cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0;
    end else begin
      pend <= (pend & ~ack_bits) | (rise & ena);
    end
  end
endmodule

// File: rtl/irq_regif.sv
module irq_regif
  import irq_agg_pkg::*;
#(
  parameter int unsigned W  = GRP_W,
  parameter int unsigned NG = N_GRP,
  parameter int unsigned AW = ADDR_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AW-1:0]   addr,
  input  logic            wr,
  input  logic            rd,
  input  logic [W-1:0]    wdata,
  input  logic [NG*W-1:0] pend_all,
  input  logic [NG*W-1:0] ena_all,
  input  logic [NG*W-1:0] level_all,
  output logic [NG-1:0]   ena_we,
  output logic [NG*W-1:0] ack_all,
  output logic [W-1:0]    rdata
);
  logic [NG-1:0] grp_hit;
  reg_sel_e      sel;
  logic [W-1:0]  rd_mux;

  assign sel = reg_sel_e'(addr[3:2]);

  for (genvar g = 0; g < NG; g++) begin : g_dec
    assign grp_hit[g] = (addr[AW-1:4] == (AW-4)'(grp_page(g))) && (addr[1:0] == 2'b00);
    assign ena_we[g]  = wr && grp_hit[g] && (sel == SEL_ENA);
    assign ack_all[g*W +: W] = (wr && grp_hit[g] && (sel == SEL_ACK)) ? wdata : '0;
  end

  always_comb begin
    rd_mux = '0;
    for (int g = 0; g < NG; g++) begin
      if (grp_hit[g]) begin
        unique case (sel)
          SEL_PEND:  rd_mux = pend_all[g*W +: W];
          SEL_ENA:   rd_mux = ena_all[g*W +: W];
          SEL_ACK:   rd_mux = '0;
          SEL_LEVEL: rd_mux = level_all[g*W +: W];
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd) begin
      rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/irq_agg_top.sv
module irq_agg_top
  import irq_agg_pkg::*;
#(
  parameter int unsigned W  = GRP_W,
  parameter int unsigned NG = N_GRP,
  parameter int unsigned AW = ADDR_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NG*W-1:0] src_in,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [W-1:0]    bus_wdata,
  output logic [W-1:0]    bus_rdata,
  output logic            irq_out
);
  localparam int unsigned NSRC = NG * W;

  logic [NSRC-1:0] pend_all;
  logic [NSRC-1:0] ena_all;
  logic [NSRC-1:0] level_all;
  logic [NSRC-1:0] ack_all;
  logic [NG-1:0]   ena_we;

  irq_regif #(.W(W), .NG(NG), .AW(AW)) u_regif (
    .clk       (clk),
    .rst       (rst),
    .addr      (bus_addr),
    .wr        (bus_wr),
    .rd        (bus_rd),
    .wdata     (bus_wdata),
    .pend_all  (pend_all),
    .ena_all   (ena_all),
    .level_all (level_all),
    .ena_we    (ena_we),
    .ack_all   (ack_all),
    .rdata     (bus_rdata)
  );

  for (genvar g = 0; g < NG; g++) begin : g_bank
    irq_bank #(.W(W)) u_bank (
      .clk       (clk),
      .rst       (rst),
      .src       (src_in[g*W +: W]),
      .ena_we    (ena_we[g]),
      .ena_wdata (bus_wdata),
      .ack_bits  (ack_all[g*W +: W]),
      .pend      (pend_all[g*W +: W]),
      .ena       (ena_all[g*W +: W]),
      .level     (level_all[g*W +: W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_out <= 1'b0;
    end else begin
      irq_out <= |(pend_all & ena_all);
    end
  end
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk #(
  parameter int unsigned N  = 64,
  parameter int unsigned W  = 32
) (
  input logic         clk,
  input logic         rst,
  input logic [N-1:0] src_in,
  input logic [N-1:0] pend_all,
  input logic [N-1:0] ena_all,
  input logic [N-1:0] ack_all,
  input logic         bus_rd,
  input logic [W-1:0] bus_rdata,
  input logic         irq_out
);
  logic [1:0] armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 2'd0;
    end else if (armed != 2'd2) begin
      armed <= armed + 2'd1;
    end
  end

  // R1: interrupt line low after a reset cycle
  p_reset_quiet_r1: assert property (@(posedge clk) rst |=> !irq_out);

  // R3, R4: a newly pending bit needs an edge while enabled
  p_set_needs_edge_r3: assert property (@(posedge clk) disable iff (rst || armed != 2'd2)
    ((pend_all & ~$past(pend_all)) & ~($past(src_in) & ~$past(src_in, 2) & $past(ena_all))) == '0);

  // R6: an enabled edge always lands, even against an acknowledge
  p_edge_wins_r6: assert property (@(posedge clk) disable iff (rst || armed != 2'd2)
    (($past(src_in) & ~$past(src_in, 2) & $past(ena_all)) & ~pend_all) == '0);

  // R5: a pending bit falls only through an acknowledge
  p_clear_needs_ack_r5: assert property (@(posedge clk) disable iff (rst || armed == 2'd0)
    ((~pend_all & $past(pend_all)) & ~$past(ack_all)) == '0);

  // R8: interrupt line follows pending AND enable one cycle later
  p_irq_follows_r8: assert property (@(posedge clk) disable iff (rst || armed == 2'd0)
    irq_out == $past(|(pend_all & ena_all)));

  // R10: read data holds when no read was sampled
  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (rst || armed == 2'd0)
    !$past(bus_rd) |-> $stable(bus_rdata));
endmodule

bind irq_agg_top irq_agg_chk #(.N(NSRC), .W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .src_in    (src_in),
  .pend_all  (pend_all),
  .ena_all   (ena_all),
  .ack_all   (ack_all),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata),
  .irq_out   (irq_out)
);

// File: tb/tb_irq_agg_top.sv
module tb_irq_agg_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] src_in = '0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_out;

  int n_checks = 0;
  int n_fail   = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;
  bit          done = 1'b0;

  irq_agg_top dut (
    .clk(clk), .rst(rst), .src_in(src_in), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) rd_seen <= bus_rd;

  // monitor: compare each read result against the queued expectation
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_checks++;
      if (bus_rdata !== e) begin
        n_fail++;
        $display("FAIL %s: rdata actual %h expected %h", t, bus_rdata, e);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_write(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic do_read(input logic [7:0] a, input logic [31:0] e, input string t);
    bus_addr = a; bus_rd = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    n_checks++;
    if (irq_out !== e) begin
      n_fail++;
      $display("FAIL %s: irq_out actual %b expected %b", t, irq_out, e);
    end
  endtask

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);
    chk_irq(1'b0, "R1 reset");
    do_read(8'h20, 32'h0, "R1 low pending");
    do_read(8'h10, 32'h0, "R1 high pending");
    do_read(8'h24, 32'h0, "R1 low enable");
    tick(1);

    do_write(8'h24, 32'h0000_00FF);
    do_write(8'h14, 32'h0000_0001);
    do_read(8'h24, 32'h0000_00FF, "R2 low enable offset");
    do_read(8'h14, 32'h0000_0001, "R2 high enable offset");

    src_in[3] = 1'b1;
    tick(2);
    chk_irq(1'b1, "R8 pending and enabled");
    do_read(8'h20, 32'h0000_0008, "R3 edge sets pending");
    do_read(8'h10, 32'h0, "R2 high group untouched");

    src_in[40] = 1'b1;
    tick(2);
    do_read(8'h10, 32'h0, "R4 disabled source");
    do_read(8'h1C, 32'h0000_0100, "R7 high levels");
    do_read(8'h2C, 32'h0000_0008, "R7 low levels");

    do_write(8'h28, 32'h0);
    do_read(8'h20, 32'h0000_0008, "R5 write zero no effect");
    do_write(8'h28, 32'h0000_0008);
    do_read(8'h20, 32'h0, "R5 ack clears");
    tick(2);
    do_read(8'h20, 32'h0, "R3 held line no re-set");
    chk_irq(1'b0, "R8 nothing pending");

    src_in[32] = 1'b1;
    tick(2);
    do_read(8'h10, 32'h0000_0001, "R2 source 32 on bit 0");
    chk_irq(1'b1, "R8 high group raises");
    do_write(8'h14, 32'h0);
    tick(1);
    chk_irq(1'b0, "R8 disable drops line");
    do_read(8'h10, 32'h0000_0001, "R8 pending kept");
    do_write(8'h18, 32'h0000_0001);
    do_write(8'h14, 32'h0000_0001);

    do_write(8'h20, 32'hFFFF_FFFF);
    do_read(8'h20, 32'h0, "R9 pending write ignored");
    do_write(8'h2C, 32'hFFFF_FFFF);
    do_read(8'h2C, 32'h0000_0008, "R9 level write ignored");
    do_read(8'h28, 32'h0, "R9 ack reads zero");

    src_in[5] = 1'b1;
    tick(2);
    src_in[5] = 1'b0;
    tick(2);
    src_in[5] = 1'b1;
    do_write(8'h28, 32'h0000_0020);
    tick(1);
    do_read(8'h20, 32'h0000_0020, "R6 set wins over ack");

    do_read(8'h30, 32'h0, "R2 unmapped reads zero");
    do_read(8'h21, 32'h0, "R2 misaligned reads zero");
    do_read(8'h24, 32'h0000_00FF, "R10 last read");
    tick(3);
    n_checks++;
    if (bus_rdata !== 32'h0000_00FF) begin
      n_fail++;
      $display("FAIL R10 hold: rdata actual %h expected %h", bus_rdata, 32'h0000_00FF);
    end
    tick(2);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule